// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers twelve interrupt sources for a small 8-bit processor core. Nine of them are internal peripheral events: an interval timer, a watchdog, four timer/counters, a serial port, an ADC and a watch timer. Each arrives as a one-cycle pulse. The other three are external pins, and each pin has its own edge polarity. Every source owns a request flag and an enable bit. A single master enable gates all of them. Among the pending, enabled requests a fixed priority picks one, and the block presents it to the core as a request line and a 4-bit source index.

When the core acknowledges, the block clears the flag on its own only if the winning source is an external pin. Internal flags stay set until software writes them to 0. A small byte-wide register port gives software read and write access to the flags, the enables, the pin polarities and the master enable.

Top module: `irq_ctrl`

## Requirements
- R1: Source index k (0 = highest priority) is assigned in this order. 0 interval timer, 1 watchdog, 2 pin 0, 3 pin 1, 4 timer 0, 5 timer 1, 6 pin 2, 7 serial, 8 ADC, 9 watch timer, 10 timer 2, 11 timer 3. A new request presents the lowest pending and enabled index on `irq_idx`.
- R2: `irq_req` is 1 only when the master enable (register 5, bit 0) was 1 and some flag with its enable bit set was pending in the previous cycle. Clearing the master enable lowers `irq_req` one cycle after the write takes effect.
- R3: A source whose enable bit is 0 never raises `irq_req`, but its flag still latches and reads back as 1.
- R4: Pin polarity is register 4, bits [2:0], one bit per pin: 1 selects a low-to-high transition and 0 selects high-to-low. Each pin passes through a two-flop synchronizer. One qualifying transition sets the pin's flag exactly once, however long the new level is held.
- R5: An acknowledge while `irq_req` is 1 clears the flag of the presented source if that source is a pin (index 2, 3 or 6). The flags of internal sources are left unchanged.
- R6: The register map is as follows, with `reg_sel` as the address:
  - 0: flags of sources 0..7 in bits 7..0.
  - 1: flags of sources 8..11 in bits 3..0.
  - 2: enables of sources 0..7.
  - 3: enables of sources 8..11 in bits 3..0.
  - 4: pin polarity.
  - 5: master enable.

  Unimplemented bits and addresses read 0, and every register resets to 0.
- R7: If a set event and a software write of 0 reach the same flag in one cycle, the flag ends up set.
- R8: While `irq_req` stays 1 and no acknowledge arrives, `irq_idx` holds its value even if a higher-priority source becomes pending. `irq_req` is 0 in the cycle after an acknowledge.
- R9: An internal event pulse sets its flag at the next clock edge. `irq_req` follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_evt | input | 9 | Internal event pulses: bit 0 interval timer, 1 watchdog, 2 timer 0, 3 timer 1, 4 serial, 5 ADC, 6 watch timer, 7 timer 2, 8 timer 3 |
| ext_pin | input | 3 | External interrupt pins 0..2, asynchronous |
| irq_ack | input | 1 | One-cycle acknowledge from the core for the presented index |
| reg_sel | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel` (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Index of the presented source |

## Verification
Some properties hold on every cycle, and the assertions check those. `irq_req` never rises without the master enable. The index holds while a request waits. The request drops right after an acknowledge. An acknowledge clears a pin flag and leaves an internal flag alone. A set event beats a software clear. A pin edge detector never fires two cycles in a row.

Other behaviour can only be seen through the bench's scenarios. These are the full priority walk over simultaneous requests, masking by enables and by the master bit, both polarities on the pins, single setting under a held level, and the exact latencies. A behavioural reference model is compared with the request, index and read-data outputs on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int N_SRC  = 12;
    localparam int N_INT  = 9;
    localparam int N_EXT  = 3;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int HI_W   = N_SRC - DATA_W;

    localparam logic [SEL_W-1:0] A_FLAG_LO = 3'd0;
    localparam logic [SEL_W-1:0] A_FLAG_HI = 3'd1;
    localparam logic [SEL_W-1:0] A_EN_LO   = 3'd2;
    localparam logic [SEL_W-1:0] A_EN_HI   = 3'd3;
    localparam logic [SEL_W-1:0] A_POL     = 3'd4;
    localparam logic [SEL_W-1:0] A_MASTER  = 3'd5;

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
        logic [N_EXT-1:0] pol;
        logic             master;
        logic             req;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    // priority slots held by external pins
    function automatic logic is_ext(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(2)) || (i == IDX_W'(3)) || (i == IDX_W'(6));
    endfunction

    // place internal pulses and pin edges into priority order
    function automatic logic [N_SRC-1:0] merge_set(input logic [N_INT-1:0] ie,
                                                   input logic [N_EXT-1:0] xe);
        logic [N_SRC-1:0] s;
        s[0]  = ie[0];
        s[1]  = ie[1];
        s[2]  = xe[0];
        s[3]  = xe[1];
        s[4]  = ie[2];
        s[5]  = ie[3];
        s[6]  = xe[2];
        s[7]  = ie[4];
        s[8]  = ie[5];
        s[9]  = ie[6];
        s[10] = ie[7];
        s[11] = ie[8];
        return s;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic pv;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = pin;
        d.s2 = q.s1;
        d.pv = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit = rise_sel ? (q.s2 & ~q.pv) : (~q.s2 & q.pv);

    // R4: a single transition yields a single-cycle detection
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $stable(rise_sel)) |=> !hit || !$stable(rise_sel));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 12,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INT-1:0]  int_evt,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic              irq_ack,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx
);
    ctrl_t q, d;

    logic [N_EXT-1:0] ext_hit;
    logic [N_SRC-1:0] set_now;
    logic [N_SRC-1:0] live;
    logic             any_live;
    logic [IDX_W-1:0] win_idx;

    for (genvar p = 0; p < N_EXT; p++) begin : g_pin
        irq_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_pin[p]),
            .rise_sel (q.pol[p]),
            .hit      (ext_hit[p])
        );
    end

    assign set_now = merge_set(int_evt, ext_hit);
    assign live    = q.flag & q.en & {N_SRC{q.master}};

    irq_prio_enc #(.N(N_SRC), .W(IDX_W)) u_enc (
        .vec (live),
        .any (any_live),
        .idx (win_idx)
    );

    always_comb begin
        d = q;
        if (irq_ack && q.req && is_ext(q.idx)) d.flag[q.idx] = 1'b0;
        if (reg_wr) begin
            case (reg_sel)
                A_FLAG_LO: d.flag[DATA_W-1:0]     = reg_wdata;
                A_FLAG_HI: d.flag[N_SRC-1:DATA_W] = reg_wdata[HI_W-1:0];
                A_EN_LO:   d.en[DATA_W-1:0]       = reg_wdata;
                A_EN_HI:   d.en[N_SRC-1:DATA_W]   = reg_wdata[HI_W-1:0];
                A_POL:     d.pol                  = reg_wdata[N_EXT-1:0];
                A_MASTER:  d.master               = reg_wdata[0];
                default: ;
            endcase
        end
        d.flag = d.flag | set_now;
        d.req  = !irq_ack && any_live;
        d.idx  = (q.req && !irq_ack && any_live) ? q.idx : win_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_sel)
            A_FLAG_LO: reg_rdata = q.flag[DATA_W-1:0];
            A_FLAG_HI: reg_rdata = {{(DATA_W-HI_W){1'b0}}, q.flag[N_SRC-1:DATA_W]};
            A_EN_LO:   reg_rdata = q.en[DATA_W-1:0];
            A_EN_HI:   reg_rdata = {{(DATA_W-HI_W){1'b0}}, q.en[N_SRC-1:DATA_W]};
            A_POL:     reg_rdata = {{(DATA_W-N_EXT){1'b0}}, q.pol};
            A_MASTER:  reg_rdata = {{(DATA_W-1){1'b0}}, q.master};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_req = q.req;
    assign irq_idx = q.idx;

    logic [N_SRC-1:0] flag_q;
    logic             master_q;
    assign flag_q   = q.flag;
    assign master_q = q.master;

    // R2: no request without the master enable one cycle earlier
    a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(master_q));

    // R8: index held while a request waits
    a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_idx)));

    // R8: request withdrawn after acknowledge
    a_r8_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req);

    // R5: pin flag cleared on acknowledge
    a_r5_pin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && is_ext(irq_idx) && !reg_wr && !set_now[irq_idx])
        |=> !flag_q[$past(irq_idx)]);

    // R5: internal flag survives acknowledge
    a_r5_internal_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !is_ext(irq_idx) && !reg_wr && flag_q[irq_idx])
        |=> flag_q[$past(irq_idx)]);

    // R7: every set event lands in its flag
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_now) |=> ((flag_q & $past(set_now)) == $past(set_now)));
endmodule

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] int_evt = '0;
    logic [2:0] ext_pin = '0;
    logic       irq_ack = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [3:0] irq_idx;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .ext_pin(ext_pin),
        .irq_ack(irq_ack), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_idx(irq_idx)
    );

    // behavioural reference model
    int   int_pos[9] = '{0, 1, 4, 5, 7, 8, 9, 10, 11};
    int   ext_pos[3] = '{2, 3, 6};
    bit   m_flag[12];
    bit   m_en[12];
    bit   m_pol[3];
    bit   m_s1[3], m_s2[3], m_pv[3];
    bit   m_master;
    bit   m_req;
    int   m_idx;

    function automatic bit m_is_pin(int i);
        return (i == 2) || (i == 3) || (i == 6);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 12; i++) begin m_flag[i] = 0; m_en[i] = 0; end
            for (int p = 0; p < 3; p++) begin
                m_pol[p] = 0; m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0;
            end
            m_master = 0; m_req = 0; m_idx = 0;
        end else begin
            bit nf[12];
            bit edge_seen[3];
            int best;
            bit found;
            for (int p = 0; p < 3; p++)
                edge_seen[p] = m_pol[p] ? (m_s2[p] && !m_pv[p]) : (!m_s2[p] && m_pv[p]);
            found = 0; best = 0;
            for (int i = 0; i < 12; i++)
                if (!found && m_master && m_flag[i] && m_en[i]) begin found = 1; best = i; end
            nf = m_flag;
            if (irq_ack && m_req && m_is_pin(m_idx)) nf[m_idx] = 0;
            if (reg_wr) begin
                case (reg_sel)
                    3'd0: for (int i = 0; i < 8; i++) nf[i] = reg_wdata[i];
                    3'd1: for (int i = 0; i < 4; i++) nf[8+i] = reg_wdata[i];
                    3'd2: for (int i = 0; i < 8; i++) m_en[i] = reg_wdata[i];
                    3'd3: for (int i = 0; i < 4; i++) m_en[8+i] = reg_wdata[i];
                    3'd5: m_master = reg_wdata[0];
                    default: ;
                endcase
            end
            for (int k = 0; k < 9; k++) if (int_evt[k]) nf[int_pos[k]] = 1;
            for (int p = 0; p < 3; p++) if (edge_seen[p]) nf[ext_pos[p]] = 1;
            if (m_req && !irq_ack && found) m_idx = m_idx;
            else m_idx = best;
            m_req = !irq_ack && found;
            m_flag = nf;
            for (int p = 0; p < 3; p++) begin
                m_pv[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = ext_pin[p];
            end
            if (reg_wr && reg_sel == 3'd4) for (int p = 0; p < 3; p++) m_pol[p] = reg_wdata[p];
        end
    end

    function automatic int m_read(int sel);
        int v = 0;
        case (sel)
            0: for (int i = 0; i < 8; i++) v += int'(m_flag[i]) << i;
            1: for (int i = 0; i < 4; i++) v += int'(m_flag[8+i]) << i;
            2: for (int i = 0; i < 8; i++) v += int'(m_en[i]) << i;
            3: for (int i = 0; i < 4; i++) v += int'(m_en[8+i]) << i;
            4: for (int p = 0; p < 3; p++) v += int'(m_pol[p]) << p;
            5: v = int'(m_master);
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 irq_req vs model", int'(irq_req), int'(m_req));
            if (m_req) chk("R1 irq_idx vs model", int'(irq_idx), m_idx);
            chk("R6 reg_rdata vs model", int'(reg_rdata), m_read(int'(reg_sel)));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, int v);
        step(1); reg_sel = 3'(a); reg_wdata = 8'(v); reg_wr = 1'b1;
        step(1); reg_wr = 1'b0;
    endtask

    task automatic pulse(int m);
        step(1); int_evt = 9'(m);
        step(1); int_evt = '0;
    endtask

    task automatic ack();
        step(1); irq_ack = 1'b1;
        step(1); irq_ack = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        step(1); reg_sel = 3'(a);
        @(negedge clk);
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic see(int req, int idx, string tag);
        @(negedge clk);
        chk(tag, int'(irq_req), req);
        if (req != 0) chk(tag, int'(irq_idx), idx);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int order[9] = '{0, 1, 4, 5, 7, 8, 9, 10, 11};
        int fa;
        int fb;
        step(3);
        rst_n = 1'b1;
        // R6 reset values
        for (int a = 0; a < 8; a++) rd(a, 0, "R6 reset register");
        see(0, 0, "R6 reset request");

        // R3: disabled source still latches
        pulse(9'h004);
        rd(0, 8'h10, "R3 latch while disabled");
        see(0, 0, "R3 no request while disabled");
        wr(0, 0);

        // R1 priority walk with all internal sources at once
        wr(2, 8'hFF); wr(3, 8'h0F); wr(5, 1);
        pulse(9'h1FF);
        rd(0, 8'hB3, "R1 flags low");
        rd(1, 8'h0F, "R1 flags high");
        step(2);
        see(1, 0, "R1 highest first");
        ack(); step(3);
        see(1, 0, "R5 internal flag kept after ack");
        rd(0, 8'hB3, "R5 internal flag readback");
        fa = 8'hB3; fb = 8'h0F;
        for (int k = 0; k < 8; k++) begin
            if (order[k] < 8) begin fa &= ~(1 << order[k]); wr(0, fa); end
            else begin fb &= ~(1 << (order[k] - 8)); wr(1, fb); end
            ack(); step(3);
            see(1, order[k+1], "R1 next priority");
        end
        wr(1, 0); step(3);
        see(0, 0, "R1 all cleared");

        // R9 latency and R2 master gate
        step(1); int_evt = 9'h001;
        step(1); int_evt = '0;
        @(negedge clk); chk("R9 request not yet", int'(irq_req), 0);
        @(negedge clk); chk("R9 request after two edges", int'(irq_req), 1);
        wr(5, 0); step(2);
        see(0, 0, "R2 master off blocks");
        wr(5, 1); step(2);
        see(1, 0, "R2 master on restores");
        wr(2, 8'hFE); step(2);
        see(0, 0, "R3 enable off blocks");
        wr(0, 0); wr(2, 8'hFF);

        // R4 pin polarity: pin0 rising, pin1 falling
        wr(4, 3'b001);
        step(1); ext_pin = 3'b001;
        step(4);
        rd(0, 8'h04, "R4 rising edge sets pin0");
        see(1, 2, "R4 pin0 index");
        wr(0, 0); step(5);
        rd(0, 8'h00, "R4 held level sets once");
        step(1); ext_pin = 3'b011;
        step(4);
        rd(0, 8'h00, "R4 rising ignored on falling pin");
        step(1); ext_pin = 3'b001;
        step(4);
        rd(0, 8'h08, "R4 falling edge sets pin1");
        see(1, 3, "R4 pin1 index");

        // R5 auto-clear on pin acknowledge
        ack(); step(1);
        rd(0, 8'h00, "R5 pin flag auto-cleared");
        step(1); ext_pin = 3'b000;
        step(4);

        // R8 index hold while waiting
        pulse(9'h004); step(3);
        see(1, 4, "R8 timer0 presented");
        pulse(9'h001); step(3);
        see(1, 4, "R8 index held");
        ack(); step(3);
        see(1, 0, "R8 higher source after ack");
        wr(0, 0); step(2);

        // R7 set beats software clear
        step(1); reg_sel = 3'd0; reg_wdata = 8'h00; reg_wr = 1'b1; int_evt = 9'h001;
        step(1); reg_wr = 1'b0; int_evt = '0;
        rd(0, 8'h01, "R7 set wins over clear");
        wr(0, 0); step(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule